// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a parallel flash bus made of several byte-wide devices that share one chip select, one output enable and one address bus, each with its own write enable. It takes one high-level request (program one word, erase one sector, or erase the whole array) and turns it into the unlock write cycles the flash needs. It then reads the target location again and again until bit 7 of every selected byte lane shows the final value, which signals that the embedded operation inside the flash has finished.

Each byte lane is treated as a separate device working in parallel. Command bytes are copied onto every lane and only the write enables of the selected lanes are pulsed. The write-cycle phases (address setup, write-enable low time, hold time), the output-enable recovery before writes and the length of each status read are whole clock cycles set by parameters. A companion SRAM on the same data bus has its select held inactive at all times. A poll limit supplied with the request bounds the wait: when the limit is reached the block reports an error instead of completion.

Top module: `flash_cmd_seq`

## Requirements
- R1: With `req_op` = 00 (program) the block issues exactly four write cycles, in this order: byte AAh at address 5555h, byte 55h at 2AAAh, byte A0h at 5555h, then the request data at the request address.
- R2: With `req_op` = 01 (sector erase) or 10 (full erase) the block issues six write cycles: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and then 30h at the request address (sector) or 10h at 5555h (full).
- R3: Byte lane l is `fl_wdata[8l+7:8l]` and is written by `fl_we_n[l]`. Command bytes appear on all lanes. Only lanes whose `req_lane_en` bit is 1 see a write-enable pulse, and for a program the data step carries `req_data` unchanged.
- R4: Every write cycle keeps the flash select low and the address and data driven for SETUP_CYC cycles with the write enable high. The write enable is then low for PULSE_CYC cycles, then high with address and data unchanged for HOLD_CYC cycles. Consecutive pulses are separated by HOLD_CYC+SETUP_CYC high cycles. A write enable is never low while the output enable is low or the flash select is high.
- R5: After a request is accepted the output enable and the flash select stay high for RECOV_CYC cycles before the first write cycle begins.
- R6: HOLD_CYC cycles after the last write pulse, the block reads the request address with the flash select and output enable low for READ_CYC cycles, with one output-enable-high cycle between reads. Each enabled lane's bit 7 is compared with its expected value: bit 7 of that lane's program data, or 1 after an erase. When all enabled lanes match, `done` pulses for exactly one cycle.
- R7: If the number of mismatching reads reaches `req_limit` (a limit of 0 acts as 1), `error` pulses for one cycle instead of `done` and the block returns to idle. `done` and `error` never pulse together.
- R8: `sram_cs_n` is high in every cycle.
- R9: `busy` is high from the cycle after a request is accepted until the cycle in which `done` or `error` pulses, when it is low. Requests arriving while `busy` is high are ignored and change nothing on the bus.
- R10: A request with `req_op` = 11 or with `req_lane_en` = 0 is ignored: `busy` stays low and the flash select stays high.
- R11: In and after reset, before any request: `fl_cs_n`, `fl_oe_n`, all `fl_we_n` and `sram_cs_n` are high; `busy`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 00 program, 01 sector erase, 10 full erase, 11 none |
| req_addr | input | ADDR_W | Target address (program location, sector, or poll address) |
| req_data | input | 8*LANES | Program data, one byte per lane |
| req_lane_en | input | LANES | Selected byte lanes |
| req_limit | input | LIMIT_W | Number of mismatching status reads allowed |
| fl_rdata | input | 8*LANES | Data read from the flash bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle timeout pulse |
| fl_cs_n | output | 1 | Flash chip select, active low |
| sram_cs_n | output | 1 | SRAM chip select, held high |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | LANES | Per-lane write enables, active low |
| fl_addr | output | ADDR_W | Bus address |
| fl_wdata | output | 8*LANES | Write data |
| fl_wdrive | output | 1 | High while the block drives the data bus |

## Verification
A wrong step index or state in the sequencer shows up at the next write pulse as a wrong address, byte or lane mask, or as a wrong pulse count, so a bus monitor that logs every pulse catches it within one write cycle. A wrong phase counter changes the measured spacing of write-enable and output-enable edges within a few cycles. A fault in the lane compare or in the poll counter shows up as a wrong read count or a wrong done/error result at the end of the operation. A flash model that holds bit 7 inverted on each lane for a chosen number of reads, and always inverted on disabled lanes, makes both the completion and the timeout paths reachable.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_SECT  = 2'b01,
        OP_CHIP  = 2'b10,
        OP_NONE  = 2'b11
    } fop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECOV,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_READ,
        S_GAP
    } fstate_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_FULL  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_phase_timer.sv
`timescale 1ns/1ps
module flash_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_table.sv
`timescale 1ns/1ps
module flash_cmd_table
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int LANES  = 4,
    localparam int DATA_W = 8 * LANES
) (
    input  fop_e              op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              last_step
);

    logic [7:0] key_b;
    logic       pick_tgt_addr;
    logic       pick_tgt_data;
    logic       addr_is_b;

    always_comb begin
        key_b         = KEY_FIRST;
        addr_is_b     = 1'b0;
        pick_tgt_addr = 1'b0;
        pick_tgt_data = 1'b0;
        case (step)
            3'd0: key_b = KEY_FIRST;
            3'd1: begin
                key_b     = KEY_SECOND;
                addr_is_b = 1'b1;
            end
            3'd2: key_b = (op == OP_PROG) ? CODE_PROG : CODE_ERASE;
            3'd3: begin
                key_b         = KEY_FIRST;
                pick_tgt_addr = (op == OP_PROG);
                pick_tgt_data = (op == OP_PROG);
            end
            3'd4: begin
                key_b     = KEY_SECOND;
                addr_is_b = 1'b1;
            end
            default: begin
                key_b         = (op == OP_SECT) ? CODE_SECT : CODE_FULL;
                pick_tgt_addr = (op == OP_SECT);
            end
        endcase
    end

    always_comb begin
        if (pick_tgt_addr) begin
            cmd_addr = tgt_addr;
        end else if (addr_is_b) begin
            cmd_addr = ADDR_W'(UNLOCK_ADDR_B);
        end else begin
            cmd_addr = ADDR_W'(UNLOCK_ADDR_A);
        end
        cmd_data  = pick_tgt_data ? tgt_data : {LANES{key_b}};
        last_step = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
    end

endmodule

// File: rtl/flash_poll_match.sv
`timescale 1ns/1ps
module flash_poll_match #(
    parameter int LANES = 4,
    localparam int DATA_W = 8 * LANES
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  lane_en,
    input  logic [LANES-1:0]  want_bit7,
    output logic              all_ok
);

    logic [LANES-1:0] lane_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_ok[l] = !lane_en[l] || (rdata[8*l+7] == want_bit7[l]);
    end

    assign all_ok = &lane_ok;

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int LANES     = 4,
    parameter int LIMIT_W   = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2,
    parameter int RECOV_CYC = 2,
    parameter int READ_CYC  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [8*LANES-1:0]   req_data,
    input  logic [LANES-1:0]     req_lane_en,
    input  logic [LIMIT_W-1:0]   req_limit,
    input  logic [8*LANES-1:0]   fl_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic                 fl_cs_n,
    output logic                 sram_cs_n,
    output logic                 fl_oe_n,
    output logic [LANES-1:0]     fl_we_n,
    output logic [ADDR_W-1:0]    fl_addr,
    output logic [8*LANES-1:0]   fl_wdata,
    output logic                 fl_wdrive
);

    localparam int DATA_W = 8 * LANES;
    localparam int PH_MAX = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(HOLD_CYC, RECOV_CYC)), READ_CYC);
    localparam int CW     = $clog2(PH_MAX + 1);

    typedef struct packed {
        fstate_e             st;
        fop_e                op;
        logic [2:0]          step;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [LANES-1:0]    lanes;
        logic [LIMIT_W-1:0]  limit;
        logic [LIMIT_W-1:0]  fails;
        logic                done;
        logic                err;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic            t_load;
    logic [CW-1:0]   t_val;
    logic            t_exp;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic            last_step;
    logic [LANES-1:0] want_bit7;
    logic            poll_ok;
    logic [LIMIT_W:0] fails_inc;
    logic            in_write;

    flash_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    flash_cmd_table #(.ADDR_W(ADDR_W), .LANES(LANES)) u_table (
        .op        (seq_q.op),
        .step      (seq_q.step),
        .tgt_addr  (seq_q.addr),
        .tgt_data  (seq_q.data),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .last_step (last_step)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            want_bit7[l] = (seq_q.op == OP_PROG) ? seq_q.data[8*l+7] : 1'b1;
        end
    end

    flash_poll_match #(.LANES(LANES)) u_match (
        .rdata     (fl_rdata),
        .lane_en   (seq_q.lanes),
        .want_bit7 (want_bit7),
        .all_ok    (poll_ok)
    );

    assign fails_inc = {1'b0, seq_q.fails} + {{LIMIT_W{1'b0}}, 1'b1};

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        case (seq_q.st)
            S_IDLE: begin
                if (req_valid && (fop_e'(req_op) != OP_NONE) && (req_lane_en != '0)) begin
                    seq_d.st    = S_RECOV;
                    seq_d.op    = fop_e'(req_op);
                    seq_d.addr  = req_addr;
                    seq_d.data  = req_data;
                    seq_d.lanes = req_lane_en;
                    seq_d.limit = req_limit;
                    seq_d.step  = 3'd0;
                    seq_d.fails = '0;
                    t_load      = 1'b1;
                    t_val       = CW'(RECOV_CYC - 1);
                end
            end
            S_RECOV: begin
                if (t_exp) begin
                    seq_d.st = S_SETUP;
                    t_load   = 1'b1;
                    t_val    = CW'(SETUP_CYC - 1);
                end
            end
            S_SETUP: begin
                if (t_exp) begin
                    seq_d.st = S_PULSE;
                    t_load   = 1'b1;
                    t_val    = CW'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (t_exp) begin
                    seq_d.st = S_HOLD;
                    t_load   = 1'b1;
                    t_val    = CW'(HOLD_CYC - 1);
                end
            end
            S_HOLD: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (last_step) begin
                        seq_d.st = S_READ;
                        t_val    = CW'(READ_CYC - 1);
                    end else begin
                        seq_d.st   = S_SETUP;
                        seq_d.step = seq_q.step + 3'd1;
                        t_val      = CW'(SETUP_CYC - 1);
                    end
                end
            end
            S_READ: begin
                if (t_exp) begin
                    if (poll_ok) begin
                        seq_d.st   = S_IDLE;
                        seq_d.done = 1'b1;
                    end else if (fails_inc >= {1'b0, seq_q.limit}) begin
                        seq_d.st  = S_IDLE;
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st    = S_GAP;
                        seq_d.fails = fails_inc[LIMIT_W-1:0];
                        t_load      = 1'b1;
                        t_val       = '0;
                    end
                end
            end
            S_GAP: begin
                if (t_exp) begin
                    seq_d.st = S_READ;
                    t_load   = 1'b1;
                    t_val    = CW'(READ_CYC - 1);
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, op: OP_NONE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_write  = (seq_q.st == S_SETUP) || (seq_q.st == S_PULSE) || (seq_q.st == S_HOLD);
    assign fl_cs_n   = !(in_write || (seq_q.st == S_READ) || (seq_q.st == S_GAP));
    assign fl_oe_n   = (seq_q.st != S_READ);
    assign fl_we_n   = (seq_q.st == S_PULSE) ? ~seq_q.lanes : '1;
    assign fl_wdrive = in_write;
    assign fl_addr   = in_write ? cmd_addr : seq_q.addr;
    assign fl_wdata  = in_write ? cmd_data : '0;
    assign sram_cs_n = 1'b1;
    assign busy      = (seq_q.st != S_IDLE);
    assign done      = seq_q.done;
    assign error     = seq_q.err;

    // R4
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n != '1) |-> (!fl_cs_n && fl_oe_n));

    // R4
    we_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fl_we_n != '1) && $past(fl_we_n != '1)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    // R6
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!fl_oe_n));

    // R7
    err_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> ($past(!fl_oe_n) && !done));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || error));

    // R9
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);

    // R5
    write_after_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_cs_n) |-> $past(busy));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int AW = 17;
    localparam int SU = 2;
    localparam int PW = 3;
    localparam int HD = 2;
    localparam int RC = 2;
    localparam int RD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lane_en = '0;
    logic [15:0] req_limit = '0;
    logic [31:0] fl_rdata;
    logic        busy, done, error, fl_cs_n, sram_cs_n, fl_oe_n, fl_wdrive;
    logic [3:0]  fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [31:0] fl_wdata;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .LANES(4), .LIMIT_W(16), .SETUP_CYC(SU), .PULSE_CYC(PW),
                    .HOLD_CYC(HD), .RECOV_CYC(RC), .READ_CYC(RD)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_lane_en(req_lane_en), .req_limit(req_limit), .fl_rdata(fl_rdata),
        .busy(busy), .done(done), .error(error), .fl_cs_n(fl_cs_n), .sram_cs_n(sram_cs_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_wdrive(fl_wdrive)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // flash model: bit 7 of enabled lanes is inverted until polls_left reaches zero
    int       polls_left = 0;
    bit       armed = 1'b0;
    logic [3:0] mdl_lanes = '0;
    logic [3:0] mdl_bits = '0;

    always @(posedge fl_oe_n) begin
        if (armed && polls_left > 0) polls_left--;
    end

    always_comb begin
        for (int l = 0; l < 4; l++) begin
            fl_rdata[8*l +: 8] = {(mdl_lanes[l] && polls_left == 0) ? mdl_bits[l] : ~mdl_bits[l], 7'h2B};
        end
    end

    // bus monitor
    int mon_nw, mon_bad_pw, mon_bad_gap, mon_bad_hold, mon_first_setup, mon_tail;
    int mon_recov, mon_reads, mon_bad_read, mon_overlap, mon_sram, mon_cs_low;
    int setup_cnt, pw_cnt, gap_cnt, rd_len, cyc;
    logic [AW-1:0] m_addr [8];
    logic [31:0]   m_data [8];
    logic [3:0]    m_mask [8];
    logic [AW-1:0] cap_a, tgt;
    logic [31:0]   cap_d;
    bit prev_we = 1'b0, prev_oe_low = 1'b0;

    task automatic mon_clear();
        mon_nw = 0; mon_bad_pw = 0; mon_bad_gap = 0; mon_bad_hold = 0; mon_first_setup = -1;
        mon_tail = -1; mon_recov = 0; mon_reads = 0; mon_bad_read = 0; mon_overlap = 0;
        mon_sram = 0; mon_cs_low = 0; setup_cnt = 0;
    endtask

    always @(negedge clk) begin
        bit we_low;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst_n) begin
            we_low = (fl_we_n != 4'hF);
            if (!sram_cs_n) mon_sram++;
            if (!fl_cs_n) mon_cs_low++;
            if (we_low && (!fl_oe_n || fl_cs_n)) mon_overlap++;
            if (busy && fl_cs_n && mon_nw == 0) mon_recov++;
            if (!fl_cs_n && !we_low && mon_nw == 0) setup_cnt++;
            if (we_low) begin
                if (!prev_we) begin
                    if (mon_nw < 8) begin
                        m_addr[mon_nw] = fl_addr; m_data[mon_nw] = fl_wdata; m_mask[mon_nw] = ~fl_we_n;
                    end
                    if (mon_nw == 0) mon_first_setup = setup_cnt;
                    else if (gap_cnt != HD + SU) mon_bad_gap++;
                    mon_nw++; pw_cnt = 1; cap_a = fl_addr; cap_d = fl_wdata;
                end else begin
                    pw_cnt++;
                    if (fl_addr != cap_a || fl_wdata != cap_d) mon_bad_hold++;
                end
            end else begin
                if (prev_we) begin
                    if (pw_cnt != PW) mon_bad_pw++;
                    gap_cnt = 1;
                end else begin
                    gap_cnt++;
                end
                if (mon_nw > 0 && gap_cnt <= HD && (fl_addr != cap_a || fl_wdata != cap_d || !fl_wdrive))
                    mon_bad_hold++;
            end
            if (!fl_oe_n) begin
                if (!prev_oe_low) begin
                    if (mon_reads == 0) mon_tail = gap_cnt;
                    mon_reads++; rd_len = 1;
                end else begin
                    rd_len++;
                end
                if (fl_addr != tgt || fl_cs_n || fl_wdrive) mon_bad_read++;
            end else if (prev_oe_low && rd_len != RD) begin
                mon_bad_read++;
            end
            prev_we = we_low;
            prev_oe_low = !fl_oe_n;
        end
    end

    function automatic logic [AW-1:0] e_addr(input int op, input int s, input logic [AW-1:0] t);
        case (s)
            0, 2:    return 17'h05555;
            1, 4:    return 17'h02AAA;
            3:       return (op == 0) ? t : 17'h05555;
            default: return (op == 1) ? t : 17'h05555;
        endcase
    endfunction

    function automatic logic [31:0] e_data(input int op, input int s, input logic [31:0] d);
        logic [7:0] b;
        case (s)
            0: b = 8'hAA;
            1: b = 8'h55;
            2: b = (op == 0) ? 8'hA0 : 8'h80;
            3: begin
                if (op == 0) return d;
                b = 8'hAA;
            end
            4: b = 8'h55;
            default: b = (op == 1) ? 8'h30 : 8'h10;
        endcase
        return {4{b}};
    endfunction

    task automatic run_txn(input int op, input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] lanes, input int lim, input int pl, input bit poke);
        int n, nwr, eff, exp_reads;
        bit exp_err, got_done, got_err;
        @(negedge clk);
        mon_clear();
        mdl_lanes = lanes;
        for (int l = 0; l < 4; l++) mdl_bits[l] = (op == 0) ? d[8*l+7] : 1'b1;
        polls_left = pl; armed = 1'b1; tgt = a;
        req_op = 2'(op); req_addr = a; req_data = d; req_lane_en = lanes; req_limit = 16'(lim);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_op = (op == 0) ? 2'b01 : 2'b00; req_addr = ~a; req_lane_en = 4'hF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!(done || error) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        got_done = done; got_err = error;
        chk(busy == 1'b0, "R9 busy low at result", busy, 0);
        @(negedge clk);
        chk(!done && !error, "R6 result is a single pulse", {done, error}, 0);
        armed = 1'b0;
        nwr = (op == 0) ? 4 : 6;
        eff = (lim == 0) ? 1 : lim;
        exp_err = (pl >= eff);
        exp_reads = exp_err ? eff : pl + 1;
        chk(mon_nw == nwr, (op == 0) ? "R1 write count" : "R2 write count", mon_nw, nwr);
        for (int s = 0; s < nwr && s < mon_nw && s < 8; s++) begin
            chk(m_addr[s] == e_addr(op, s, a), (op == 0) ? "R1 write address" : "R2 write address",
                m_addr[s], e_addr(op, s, a));
            chk(m_data[s] == e_data(op, s, d), "R3 lane data", m_data[s], e_data(op, s, d));
            chk(m_mask[s] == lanes, "R3 write enable lanes", m_mask[s], lanes);
        end
        chk(mon_bad_pw == 0, "R4 pulse width", mon_bad_pw, 0);
        chk(mon_bad_gap == 0, "R4 pulse spacing", mon_bad_gap, 0);
        chk(mon_bad_hold == 0, "R4 address/data hold", mon_bad_hold, 0);
        chk(mon_first_setup == SU, "R4 first setup", mon_first_setup, SU);
        chk(mon_overlap == 0, "R4 write enable vs output enable", mon_overlap, 0);
        chk(mon_recov == RC, "R5 read recovery", mon_recov, RC);
        chk(mon_tail == HD + 1, "R6 first read after hold", mon_tail, HD + 1);
        chk(mon_reads == exp_reads, "R6 read count", mon_reads, exp_reads);
        chk(mon_bad_read == 0, "R6 read cycle shape", mon_bad_read, 0);
        chk(got_done == !exp_err, "R6 done result", got_done, !exp_err);
        chk(got_err == exp_err, "R7 timeout result", got_err, exp_err);
        chk(mon_sram == 0, "R8 sram select high", mon_sram, 0);
    endtask

    task automatic ignored_req(input int op, input logic [3:0] lanes, input string tag);
        int bcnt;
        @(negedge clk);
        mon_clear();
        req_op = 2'(op); req_lane_en = lanes; req_addr = 17'h1F0F0; req_limit = 16'd3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bcnt = 0;
        for (int k = 0; k < 8; k++) begin
            if (busy) bcnt++;
            @(negedge clk);
        end
        chk(bcnt == 0, tag, bcnt, 0);
        chk(mon_cs_low == 0, tag, mon_cs_low, 0);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED1);
        mon_clear();
        cyc = 0;
        repeat (3) @(negedge clk);
        chk(fl_cs_n && fl_oe_n && fl_we_n == 4'hF && sram_cs_n, "R11 bus idle in reset",
            {fl_cs_n, fl_oe_n, fl_we_n, sram_cs_n}, 7'h7F);
        chk(!busy && !done && !error, "R11 status in reset", {busy, done, error}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(fl_cs_n && fl_oe_n && fl_we_n == 4'hF && sram_cs_n, "R11 bus idle after reset",
            {fl_cs_n, fl_oe_n, fl_we_n, sram_cs_n}, 7'h7F);
        chk(!busy && !done && !error, "R11 status after reset", {busy, done, error}, 0);

        // directed corners
        run_txn(0, 17'h0ABCD, 32'h80_7F_FF_00, 4'hF, 1, 0, 1'b0);  // R1 immediate success
        run_txn(0, 17'h1FFFF, 32'h12_C3_5A_E7, 4'b0110, 8, 3, 1'b0);
        run_txn(1, 17'h18000, 32'h0, 4'b0101, 2, 2, 1'b0);          // R7 limit reached
        run_txn(2, 17'h00000, 32'h0, 4'b1000, 0, 0, 1'b0);          // R2 full erase, limit 0
        run_txn(2, 17'h04000, 32'h0, 4'hF, 0, 1, 1'b0);             // R7 limit 0 acts as 1
        run_txn(1, 17'h0C000, 32'h0, 4'b0011, 5, 4, 1'b1);          // R9 request while busy
        run_txn(0, 17'h05555, 32'hA0A0A0A0, 4'b0001, 3, 1, 1'b1);   // R9 poke during program
        ignored_req(3, 4'hF, "R10 op 11 ignored");
        ignored_req(0, 4'h0, "R10 no lanes ignored");

        // constrained random
        for (int t = 0; t < 30; t++) begin
            int op, lim, pl;
            logic [3:0] ln;
            op = int'($urandom_range(0, 2));
            ln = 4'($urandom_range(1, 15));
            lim = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 6));
            pl = int'($urandom_range(0, 5));
            run_txn(op, 17'($urandom), $urandom, ln, lim, pl, ($urandom_range(0, 3) == 0));
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule